// File: doc/BRIEF.md
# Host Bus Handshake Acknowledge Generator

This block drives the single acknowledge line that a slave host-bus port returns to an external host. The host opens an access by asserting a read or a write strobe. The block decides, from the state of the read and write buffers, when that access may finish. It signals this on one output line. The line's active level and its starting handshake style come from two strap pins. Both are captured while reset is held.

Two handshake styles are available, and software can switch between them at run time through a two-bit mode field.

- **Acknowledge style:** the line pulses active once the access can complete. It stays active until the host removes the strobe.
- **Ready style:** the line is active during a strobe whenever the access can complete. It is pulled inactive to stretch the access with wait states while the buffers are not ready.

When the port runs with explicit address cycles, every address cycle is acknowledged at once, whatever the buffer state. The buffers, the DMA engine and the address decoding are outside this block and appear only as status inputs.

Top module: `hs_ack_gen`

## Requirements
- R1: While `rst` is high, `cfg_pol_o` takes the level of `strap_pol_i` (1 = line active low, 0 = line active high). After reset it is held, and neither strap changes nor configuration writes alter it. The line `ack_o` always equals the logical acknowledge XOR `cfg_pol_o`.
- R2: `cfg_mode_o[1]` reads 0 after reset.
- R3: After reset, `cfg_mode_o[0]` is 1 (Ready style) when `strap_pol_i` equals `strap_ack_i`, and 0 (Acknowledge style) when they differ.
- R4: A cycle with `cfg_we_i` high outside reset loads `cfg_wdata_i` into `cfg_mode_o` at that clock edge. `cfg_mode_o[0]` = 1 selects Ready style and 0 selects Acknowledge style.
- R5: In Acknowledge style the line is inactive while no strobe is present. It goes active on the third rising clock edge after a strobe rises, if the access can complete. Once active, it stays active while the strobe is held, even if the buffer status turns unfavourable. It returns inactive on the third edge after the strobe falls.
- R6: In Ready style, while a synchronized strobe is present, the line is active exactly when the access can complete. A change of buffer status shows on the line one clock edge later. With no strobe the line is inactive.
- R7: A read (`rd_strobe_i`) can complete only when `rd_valid_i` is 1 and `wr_busy_i` is 0. A write (`wr_strobe_i`) can complete only when `wr_full_i` is 0 and `wr_busy_i` is 0.
- R8: When `acc_mode_i` is 1 and `addr_cycle_i` is high during a strobe, the access counts as an address cycle. It is acknowledged in both styles regardless of buffer status.
- R9: In Acknowledge style, if a strobe falls before the access could complete, the handshake returns to idle. The line stays inactive, and later status changes without a strobe leave it inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset; straps are captured while high |
| strap_pol_i | input | 1 | Polarity strap (asynchronous) |
| strap_ack_i | input | 1 | Level on the acknowledge pin during reset (asynchronous) |
| rd_strobe_i | input | 1 | Host read strobe, active high (asynchronous) |
| wr_strobe_i | input | 1 | Host write strobe, active high (asynchronous) |
| addr_cycle_i | input | 1 | Host marks the current strobe as an address cycle (asynchronous) |
| acc_mode_i | input | 1 | Port uses explicit address cycles |
| rd_valid_i | input | 1 | Read buffer holds valid data |
| wr_full_i | input | 1 | Write buffer is full |
| wr_busy_i | input | 1 | Port is busy completing a write |
| cfg_we_i | input | 1 | Configuration mode field write enable |
| cfg_wdata_i | input | 2 | New mode field value |
| cfg_mode_o | output | 2 | Mode field; bit 0 selects the handshake style |
| cfg_pol_o | output | 1 | Latched line polarity, read only |
| ack_o | output | 1 | Registered acknowledge / ready line |

## Verification
The assertions assume a host that never asserts a read and a write strobe together. They also assume the buffer status and configuration inputs are synchronous to `clk`, and the straps stay steady for at least the last three cycles of reset. The stimulus changes every input only on falling clock edges and holds the straps through reset. It raises one strobe at a time and keeps each strobe level for at least three cycles, so the two-stage synchronizers always deliver clean single transitions.

// File: rtl/hs_ack_pkg.sv
package hs_ack_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_WAIT = 2'd1,
    HS_DONE = 2'd2
  } hs_state_t;

  localparam int MODE_W         = 2;
  localparam int MODE_STYLE_BIT = 0;
  localparam int SYNC_DEFAULT   = 2;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) pipe[0] <= d_i;

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) pipe[g] <= pipe[g-1];
  end

  assign q_o = pipe[LAST];
endmodule

// File: rtl/hs_cfg_reg.sv
module hs_cfg_reg
  import hs_ack_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_pol_s,
  input  logic              strap_ack_s,
  input  logic              we_i,
  input  logic [MODE_W-1:0] wdata_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              pol_o
);
  logic [MODE_W-1:0] mode_q;
  logic              pol_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q                  <= strap_pol_s;
      mode_q                 <= '0;
      mode_q[MODE_STYLE_BIT] <= ~(strap_pol_s ^ strap_ack_s);
    end else if (we_i) begin
      mode_q <= wdata_i;
    end
  end

  assign mode_o = mode_q;
  assign pol_o  = pol_q;

  // R1
  pol_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(pol_q));

  // R2
  mode_hi_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> mode_q[MODE_W-1] == 1'b0);

  // R4
  mode_load_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(we_i) && !$past(rst)) |-> mode_q == $past(wdata_i));
endmodule

// File: rtl/hs_ack_fsm.sv
module hs_ack_fsm
  import hs_ack_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  input  logic ok_i,
  input  logic ready_style_i,
  input  logic pol_i,
  output logic line_o
);
  hs_state_t state_q, state_n;
  logic      act_n;
  logic      line_q;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      HS_IDLE: if (strobe_i) state_n = ok_i ? HS_DONE : HS_WAIT;
      HS_WAIT: if (!strobe_i) state_n = HS_IDLE;
               else if (ok_i) state_n = HS_DONE;
      HS_DONE: if (!strobe_i) state_n = HS_IDLE;
      default: state_n = HS_IDLE;
    endcase
  end

  assign act_n = ready_style_i ? (strobe_i & ok_i) : (state_n == HS_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= HS_IDLE;
      line_q  <= pol_i;
    end else begin
      state_q <= state_n;
      line_q  <= act_n ^ pol_i;
    end
  end

  assign line_o = line_q;

  // R5
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == HS_DONE && !strobe_i) |=> state_q == HS_IDLE);

  // R9
  early_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == HS_WAIT && !strobe_i) |=> state_q == HS_IDLE);

  // R7
  hold_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == HS_IDLE && strobe_i && !ok_i) |=> state_q == HS_WAIT);
endmodule

// File: rtl/hs_ack_gen.sv
module hs_ack_gen
  import hs_ack_pkg::*;
#(
  parameter int SYNC_STAGES = SYNC_DEFAULT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_pol_i,
  input  logic              strap_ack_i,
  input  logic              rd_strobe_i,
  input  logic              wr_strobe_i,
  input  logic              addr_cycle_i,
  input  logic              acc_mode_i,
  input  logic              rd_valid_i,
  input  logic              wr_full_i,
  input  logic              wr_busy_i,
  input  logic              cfg_we_i,
  input  logic [MODE_W-1:0] cfg_wdata_i,
  output logic [MODE_W-1:0] cfg_mode_o,
  output logic              cfg_pol_o,
  output logic              ack_o
);
  localparam int HOST_W  = 3;
  localparam int STRAP_W = 2;

  logic [HOST_W-1:0]  host_s;
  logic [STRAP_W-1:0] strap_s;
  logic               rd_s, wr_s, adr_s, strobe_s;
  logic               can_rd, can_wr, addr_hit, ok;
  logic [MODE_W-1:0]  mode;
  logic               pol;

  hs_sync #(.WIDTH(HOST_W), .STAGES(SYNC_STAGES)) u_host_sync (
    .clk (clk),
    .d_i ({rd_strobe_i, wr_strobe_i, addr_cycle_i}),
    .q_o (host_s)
  );

  hs_sync #(.WIDTH(STRAP_W), .STAGES(SYNC_STAGES)) u_strap_sync (
    .clk (clk),
    .d_i ({strap_pol_i, strap_ack_i}),
    .q_o (strap_s)
  );

  assign {rd_s, wr_s, adr_s} = host_s;
  assign strobe_s = rd_s | wr_s;

  hs_cfg_reg u_cfg (
    .clk         (clk),
    .rst         (rst),
    .strap_pol_s (strap_s[1]),
    .strap_ack_s (strap_s[0]),
    .we_i        (cfg_we_i),
    .wdata_i     (cfg_wdata_i),
    .mode_o      (mode),
    .pol_o       (pol)
  );

  assign can_rd   = rd_valid_i & ~wr_busy_i;
  assign can_wr   = ~wr_full_i & ~wr_busy_i;
  assign addr_hit = acc_mode_i & adr_s & strobe_s;
  assign ok       = addr_hit | (rd_s ? can_rd : can_wr);

  hs_ack_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .strobe_i      (strobe_s),
    .ok_i          (ok),
    .ready_style_i (mode[MODE_STYLE_BIT]),
    .pol_i         (pol),
    .line_o        (ack_o)
  );

  assign cfg_mode_o = mode;
  assign cfg_pol_o  = pol;

  // R6
  ready_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (mode[MODE_STYLE_BIT] && strobe_s && !ok) |=> ack_o == pol);

  // R8
  addr_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_hit && mode[MODE_STYLE_BIT]) |=> ack_o != pol);

  // R1
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe_s && !$past(rst)) |=> ack_o == pol);
endmodule

// File: tb/hs_ack_gen_bench.sv
`timescale 1ns/1ps
module hs_ack_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strap_pol_i = 1'b0, strap_ack_i = 1'b0;
  logic       rd_strobe_i = 1'b0, wr_strobe_i = 1'b0, addr_cycle_i = 1'b0;
  logic       acc_mode_i = 1'b0, rd_valid_i = 1'b0, wr_full_i = 1'b0, wr_busy_i = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [1:0] cfg_wdata_i = 2'b00;
  logic [1:0] cfg_mode_o;
  logic       cfg_pol_o, ack_o;

  int  n_vec = 0;
  int  n_err = 0;
  bit  pol_exp = 1'b0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  hs_ack_gen u_hs_ack_gen (
    .clk (clk), .rst (rst),
    .strap_pol_i (strap_pol_i), .strap_ack_i (strap_ack_i),
    .rd_strobe_i (rd_strobe_i), .wr_strobe_i (wr_strobe_i),
    .addr_cycle_i (addr_cycle_i), .acc_mode_i (acc_mode_i),
    .rd_valid_i (rd_valid_i), .wr_full_i (wr_full_i), .wr_busy_i (wr_busy_i),
    .cfg_we_i (cfg_we_i), .cfg_wdata_i (cfg_wdata_i),
    .cfg_mode_o (cfg_mode_o), .cfg_pol_o (cfg_pol_o), .ack_o (ack_o)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // logical acknowledge expected -> line level
  task automatic chk_line(input string tag, input bit active);
    chk(tag, int'(ack_o), int'(active ^ pol_exp));
  endtask

  task automatic t_reset(input bit p, input bit a);
    rst = 1'b1; strap_pol_i = p; strap_ack_i = a;
    step(5);
    rst = 1'b0;
    step(1);
    pol_exp = p;
    chk("R1 pol latched", int'(cfg_pol_o), int'(p));
    chk("R2 mode bit1 clear", int'(cfg_mode_o[1]), 0);
    chk("R3 style from straps", int'(cfg_mode_o[0]), int'(p == a));
    chk_line("R1 idle level", 1'b0);
    strap_pol_i = ~p; strap_ack_i = ~a;
    step(4);
    chk("R1 strap change ignored", int'(cfg_pol_o), int'(p));
    chk("R3 strap change ignored", int'(cfg_mode_o[0]), int'(p == a));
    strap_pol_i = p; strap_ack_i = a;
  endtask

  task automatic t_cfg_write(input logic [1:0] v);
    cfg_we_i = 1'b1; cfg_wdata_i = v;
    step(1);
    cfg_we_i = 1'b0;
    chk("R4 mode write", int'(cfg_mode_o), int'(v));
    chk("R1 pol unaffected by write", int'(cfg_pol_o), int'(pol_exp));
  endtask

  task automatic t_ready_read;
    rd_valid_i = 1'b1; wr_busy_i = 1'b0;
    rd_strobe_i = 1'b1;
    step(3);
    chk_line("R6 ready active on read", 1'b1);
    rd_valid_i = 1'b0;
    step(1);
    chk_line("R6 wait state on empty read buffer", 1'b0);
    rd_valid_i = 1'b1; wr_busy_i = 1'b1;
    step(1);
    chk_line("R7 read blocked by busy write", 1'b0);
    wr_busy_i = 1'b0;
    step(1);
    chk_line("R6 ready again", 1'b1);
    rd_strobe_i = 1'b0;
    step(3);
    chk_line("R6 inactive without strobe", 1'b0);
  endtask

  task automatic t_ack_write;
    wr_full_i = 1'b1;
    wr_strobe_i = 1'b1;
    step(3);
    chk_line("R7 write held while buffer full", 1'b0);
    wr_full_i = 1'b0;
    step(1);
    chk_line("R5 ack once write can complete", 1'b1);
    wr_full_i = 1'b1;
    step(1);
    chk_line("R5 ack held while strobe held", 1'b1);
    wr_strobe_i = 1'b0;
    step(2);
    chk_line("R5 ack held two edges after strobe fall", 1'b1);
    step(1);
    chk_line("R5 ack released", 1'b0);
    wr_full_i = 1'b0;
  endtask

  task automatic t_ack_timing;
    rd_valid_i = 1'b1;
    rd_strobe_i = 1'b1;
    step(2);
    chk_line("R5 not yet active after two edges", 1'b0);
    step(1);
    chk_line("R5 active on third edge", 1'b1);
    rd_strobe_i = 1'b0;
    step(3);
    chk_line("R5 released after read", 1'b0);
  endtask

  task automatic t_early_drop;
    rd_valid_i = 1'b0;
    rd_strobe_i = 1'b1;
    step(3);
    chk_line("R9 waiting read inactive", 1'b0);
    rd_strobe_i = 1'b0;
    step(3);
    chk_line("R9 idle after early drop", 1'b0);
    rd_valid_i = 1'b1;
    step(2);
    chk_line("R9 status change without strobe ignored", 1'b0);
    rd_strobe_i = 1'b1;
    step(3);
    chk_line("R9 fresh access acknowledged", 1'b1);
    rd_strobe_i = 1'b0;
    step(3);
  endtask

  task automatic t_addr_cycle(input bit acc);
    wr_busy_i = 1'b1; rd_valid_i = 1'b0;
    acc_mode_i = acc; addr_cycle_i = 1'b1;
    wr_strobe_i = 1'b1;
    step(3);
    chk_line(acc ? "R8 address cycle acknowledged" : "R8 no address mode, held",
             acc);
    wr_strobe_i = 1'b0; addr_cycle_i = 1'b0;
    step(3);
    chk_line("R8 released after address cycle", 1'b0);
    wr_busy_i = 1'b0; acc_mode_i = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    // straps equal, active high line -> Ready style
    t_reset(1'b0, 1'b0);
    t_ready_read();
    t_addr_cycle(1'b1);
    t_addr_cycle(1'b0);
    // straps differ, active low line -> Acknowledge style
    t_reset(1'b1, 1'b0);
    t_ack_timing();
    t_ack_write();
    t_early_drop();
    t_addr_cycle(1'b1);
    // switch style at run time
    t_cfg_write(2'b11);
    t_ready_read();
    t_cfg_write(2'b00);
    t_ack_timing();
    // straps differ the other way, active high, Acknowledge style
    t_reset(1'b0, 1'b1);
    t_ack_write();
    // straps equal, active low -> Ready style
    t_reset(1'b1, 1'b1);
    t_ready_read();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule